// File: doc/BRIEF.md
# Event and Cycle Counting Monitor

This block sits next to a processor core and counts what happens there. A dedicated cycle counter runs from the clock. A small set of programmable event counters each watch one strobe line, picked by an 8-bit event code. Software drives everything through one register port. Each write takes a single cycle, and reads are combinational from the current register state.

The event counters have no direct address of their own. Software first loads a selection index, and the event-code window and the count window then act on the counter that the index names. Enables are changed with write-one-to-set and write-one-to-clear registers. Each counter has its own wrap flag in a sticky status register. A debug-enable input gates all event counters: while it is low, they read as zero and are held at zero. The cycle counter does not depend on it and keeps running.

Register map (4-bit address):

| Address | Register |
|---|---|
| 0 | control |
| 1 | enable-set |
| 2 | enable-clear |
| 3 | wrap status |
| 4 | software increment (write only) |
| 5 | selection |
| 6 | selected event code |
| 7 | selected event count |
| 8 | cycle count |

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, the control register reads 0x41093000. The enable mask, the wrap status, the selection, every event code, every event count and the cycle count read 0.
- R2: A write to address 5 keeps only bits 4:0 as the selection, and reading address 5 returns them with bits 31:5 at zero.
- R3: Enable bits sit at positions 0..3 for the event counters and at position 31 for the cycle counter. Writing 1 to a bit at address 1 sets that enable, and writing 1 at address 2 clears it. Writing 0 changes nothing. Reading either address returns the current mask.
- R4: Address 6 reads and writes the event code (bits 7:0) of the counter named by the selection. When the selection is 4 or more, reads return 0 and writes change no code.
- R5: An event counter with code k in 1..8 adds one on each clock where ev_in[k-1] is high, control bit 0 is 1, its enable is set and dbg_en is high. Codes above 8 never count.
- R6: A wrap status bit (0..3 for the event counters, 31 for the cycle counter) becomes 1 when its counter steps from 0xFFFFFFFF to 0. It stays 1 until a write of 1 to that bit at address 3.
- R7: When control bit 0 and enable bit 31 are set, the cycle counter adds one every clock, whatever dbg_en is. With control bit 3 set, it adds one once every 64 such clocks instead.
- R8: While dbg_en is low, address 7 reads 0 and every event counter is cleared, so counting restarts from 0 once dbg_en rises.
- R9: Writing control bit 1 clears all event counters, and writing control bit 2 clears the cycle counter and its 64-clock divider. Both act once and read back as 0. Control bits 0 and 3 read back as written.
- R10: Writing 1 to bit i at address 4 adds one to event counter i only if its code is 0x00, its enable is set, control bit 0 is set and dbg_en is high. Address 4 reads 0.
- R11: A write to address 7 (when the selection is below 4) or to address 8 loads that counter. A write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_en | input | 1 | Debug enable; low holds event counters at zero |
| ev_in | input | 8 | Event strobes, one per event code 1..8 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
Every write, strobe and enable change shows up in the register state at the first clock edge after it is presented. Reads are combinational, so a value is due on reg_rdata in the cycle that follows its stimulus. The one exception is dbg_en low, which forces address 7 to zero in the same cycle. The 64-clock divider delays cycle counts by whole windows of qualifying clocks, and the reference model counts those windows as well. The bench updates its model on each rising edge from the inputs held since the previous falling edge, and compares reg_rdata against the model a quarter period after every rising edge.

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
  parameter int          NUM_CNT = 4,
  parameter int          NUM_SRC = 8,
  parameter int          PRESC   = 64,
  parameter logic [31:0] ID_VAL  = 32'h4109_3000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dbg_en,
  input  logic [NUM_SRC-1:0] ev_in,
  input  logic               reg_wr,
  input  logic [3:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata
);
  localparam int IW = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(PRESC - 1);

  logic ctrl_e, ctrl_d, en_cy, ov_cy;
  logic [NUM_CNT-1:0] en_ev, ov_ev, ev_inc, ev_wrap, ev_sel;
  logic [4:0] sel_q;
  logic [NUM_CNT-1:0][7:0]  typ_q;
  logic [NUM_CNT-1:0][31:0] cnt_q;
  logic [31:0] cyc_q, en_mask, ov_mask;
  logic [PW-1:0] pre_q;

  wire wr_ctrl = reg_wr && reg_addr == 4'd0;
  wire wr_set  = reg_wr && reg_addr == 4'd1;
  wire wr_clr  = reg_wr && reg_addr == 4'd2;
  wire wr_ovf  = reg_wr && reg_addr == 4'd3;
  wire wr_swi  = reg_wr && reg_addr == 4'd4;
  wire wr_sel  = reg_wr && reg_addr == 4'd5;
  wire wr_typ  = reg_wr && reg_addr == 4'd6;
  wire wr_cnt  = reg_wr && reg_addr == 4'd7;
  wire wr_cyc  = reg_wr && reg_addr == 4'd8;

  wire sel_ok = 32'(sel_q) < NUM_CNT;
  wire [IW-1:0] sel_idx = sel_q[IW-1:0];
  wire ev_clr = wr_ctrl && reg_wdata[1];
  wire cy_clr = wr_ctrl && reg_wdata[2];

  assign en_mask = {en_cy, {(31-NUM_CNT){1'b0}}, en_ev};
  assign ov_mask = {ov_cy, {(31-NUM_CNT){1'b0}}, ov_ev};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NUM_SRC; k++)
        if (typ_q[i] == 8'(k + 1) && ev_in[k]) hit = 1'b1;
    end
    wire sw = wr_swi && reg_wdata[i] && typ_q[i] == 8'h00;
    assign ev_sel[i]  = sel_ok && sel_idx == IW'(i);
    assign ev_inc[i]  = ctrl_e && en_ev[i] && dbg_en && (hit || sw);
    assign ev_wrap[i] = ev_inc[i] && !ev_clr && !(wr_cnt && ev_sel[i]) && (&cnt_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_e <= 1'b0;
      ctrl_d <= 1'b0;
      en_ev  <= '0;
      en_cy  <= 1'b0;
      ov_ev  <= '0;
      sel_q  <= '0;
      typ_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_e <= reg_wdata[0];
        ctrl_d <= reg_wdata[3];
      end
      if (wr_set) begin
        en_ev <= en_ev | reg_wdata[NUM_CNT-1:0];
        en_cy <= en_cy | reg_wdata[31];
      end else if (wr_clr) begin
        en_ev <= en_ev & ~reg_wdata[NUM_CNT-1:0];
        en_cy <= en_cy & ~reg_wdata[31];
      end
      if (wr_sel) sel_q <= reg_wdata[4:0];
      for (int i = 0; i < NUM_CNT; i++) begin
        if (!dbg_en || ev_clr)         cnt_q[i] <= '0;
        else if (wr_cnt && ev_sel[i])  cnt_q[i] <= reg_wdata;
        else if (ev_inc[i])            cnt_q[i] <= cnt_q[i] + 32'd1;
        if (wr_typ && ev_sel[i])       typ_q[i] <= reg_wdata[7:0];
        if (ev_wrap[i])                ov_ev[i] <= 1'b1;
        else if (wr_ovf && reg_wdata[i]) ov_ev[i] <= 1'b0;
      end
    end
  end

  wire cy_run = ctrl_e && en_cy;
  wire cy_inc = cy_run && (!ctrl_d || pre_q == PRE_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q <= '0;
      pre_q <= '0;
      ov_cy <= 1'b0;
    end else begin
      if (cy_clr)                pre_q <= '0;
      else if (cy_run && ctrl_d) pre_q <= (pre_q == PRE_TOP) ? '0 : pre_q + PW'(1);
      if (cy_clr)      cyc_q <= '0;
      else if (wr_cyc) cyc_q <= reg_wdata;
      else if (cy_inc) cyc_q <= cyc_q + 32'd1;
      if (cy_inc && !cy_clr && !wr_cyc && (&cyc_q)) ov_cy <= 1'b1;
      else if (wr_ovf && reg_wdata[31])             ov_cy <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:       reg_rdata = {ID_VAL[31:4], ctrl_d, 2'b00, ctrl_e};
      4'd1, 4'd2: reg_rdata = en_mask;
      4'd3:       reg_rdata = ov_mask;
      4'd5:       reg_rdata = {27'd0, sel_q};
      4'd6:       reg_rdata = sel_ok ? {24'd0, typ_q[sel_idx]} : 32'd0;
      4'd7:       reg_rdata = (sel_ok && dbg_en) ? cnt_q[sel_idx] : 32'd0;
      4'd8:       reg_rdata = cyc_q;
      default:    reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/perf_mon_unit_chk.sv
module perf_mon_unit_chk #(
  parameter int NUM_CNT = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dbg_en,
  input logic                     reg_wr,
  input logic [3:0]               reg_addr,
  input logic [31:0]              reg_wdata,
  input logic [4:0]               sel_q,
  input logic [31:0]              en_mask,
  input logic [31:0]              ov_mask,
  input logic                     ctrl_e,
  input logic                     ctrl_d,
  input logic [31:0]              cyc_q,
  input logic [NUM_CNT-1:0][31:0] cnt_q
);
  localparam logic [31:0] VALID = {1'b1, {(31-NUM_CNT){1'b0}}, {NUM_CNT{1'b1}}};

  p_sel_low_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd5) |=> sel_q == $past(reg_wdata[4:0]));

  p_enable_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd1) |=> ($past(reg_wdata) & VALID & ~en_mask) == 32'd0);

  p_enable_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd2) |=> ($past(reg_wdata) & en_mask) == 32'd0);

  p_wrap_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_mask[31] && !(reg_wr && reg_addr == 4'd3 && reg_wdata[31])) |=> ov_mask[31]);

  p_cycle_free_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_e && en_mask[31] && !ctrl_d && !(reg_wr && (reg_addr == 4'd0 || reg_addr == 4'd8)))
      |=> cyc_q == $past(cyc_q) + 32'd1);

  p_debug_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_en |=> cnt_q == '0);

  p_event_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd0 && reg_wdata[1]) |=> cnt_q == '0);

  p_cycle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd0 && reg_wdata[2]) |=> cyc_q == 32'd0);
endmodule

bind perf_mon_unit perf_mon_unit_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .sel_q(sel_q),
  .en_mask(en_mask), .ov_mask(ov_mask), .ctrl_e(ctrl_e), .ctrl_d(ctrl_d),
  .cyc_q(cyc_q), .cnt_q(cnt_q)
);

// File: tb/perf_mon_unit_bench.sv
module perf_mon_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_en = 1'b1;
  logic [7:0] ev_in = '0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  perf_mon_unit u_perf_mon_unit (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .ev_in(ev_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  always #10 clk = ~clk;

  bit        m_e, m_d;
  bit [31:0] m_en, m_ov, m_cyc;
  bit [31:0] m_cnt [4];
  int        m_typ [4];
  int        m_sel, m_pre;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_e = 0; m_d = 0; m_en = 0; m_ov = 0; m_cyc = 0; m_sel = 0; m_pre = 0;
      for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_typ[i] = 0; end
    end else begin
      automatic bit        w = reg_wr;
      automatic int        a = reg_addr;
      automatic bit [31:0] d = reg_wdata;
      automatic bit [31:0] n_cnt [4];
      automatic bit        run = m_e && m_en[31];
      automatic bit        tick = 0;
      for (int i = 0; i < 4; i++) begin
        automatic bit hit = (m_typ[i] >= 1 && m_typ[i] <= 8) ? ev_in[m_typ[i]-1] : 1'b0;
        automatic bit sw  = w && a == 4 && d[i] && m_typ[i] == 0;
        automatic bit inc = m_e && m_en[i] && dbg_en && (hit || sw);
        n_cnt[i] = m_cnt[i];
        if (!dbg_en || (w && a == 0 && d[1])) n_cnt[i] = 0;
        else if (w && a == 7 && m_sel == i) n_cnt[i] = d;
        else if (inc) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) m_ov[i] = 1;
          n_cnt[i] = m_cnt[i] + 1;
        end
        if (!(inc && m_cnt[i] == 32'hFFFF_FFFF && n_cnt[i] == 0 && dbg_en &&
              !(w && a == 0 && d[1])) && w && a == 3 && d[i]) m_ov[i] = 0;
      end
      if (run) begin
        if (!m_d) tick = 1;
        else if (m_pre == 63) tick = 1;
      end
      if (w && a == 0 && d[2]) begin
        m_cyc = 0; m_pre = 0;
        if (w && a == 3 && d[31]) m_ov[31] = 0;
      end else begin
        if (run && m_d) m_pre = (m_pre == 63) ? 0 : m_pre + 1;
        if (w && a == 8) begin
          m_cyc = d;
          if (a == 3 && d[31]) m_ov[31] = 0;
        end else if (tick) begin
          if (m_cyc == 32'hFFFF_FFFF) m_ov[31] = 1;
          else if (w && a == 3 && d[31]) m_ov[31] = 0;
          m_cyc = m_cyc + 1;
        end else if (w && a == 3 && d[31]) m_ov[31] = 0;
      end
      for (int i = 0; i < 4; i++) m_cnt[i] = n_cnt[i];
      if (w && a == 0) begin m_e = d[0]; m_d = d[3]; end
      if (w && a == 1) m_en = m_en | (d & 32'h8000_000F);
      if (w && a == 2) m_en = m_en & ~d;
      if (w && a == 5) m_sel = int'(d[4:0]);
      if (w && a == 6 && m_sel < 4) m_typ[m_sel] = int'(d[7:0]);
    end
  end

  function automatic bit [31:0] model_read(int a);
    case (a)
      0: return {28'h4109300, m_d, 2'b00, m_e};
      1, 2: return m_en;
      3: return m_ov;
      5: return 32'(m_sel);
      6: return (m_sel < 4) ? 32'(m_typ[m_sel]) : 32'd0;
      7: return (m_sel < 4 && dbg_en) ? m_cnt[m_sel] : 32'd0;
      8: return m_cyc;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R9";
      1, 2: return "R3";
      3: return "R6";
      4: return "R10";
      5: return "R2";
      6: return "R4";
      7: return "R5";
      8: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%0d actual=%h expected=%h t=%0t", tag, reg_addr, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) check(tag_of(reg_addr), reg_rdata, model_read(reg_addr));
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
  endtask

  task automatic rd(int a, int n = 1);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 4'(a);
    end
  endtask

  task automatic expect_at(int a, logic [31:0] exp, string tag);
    rd(a);
    @(posedge clk); #5;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rd(0, 3);
    @(negedge clk); rst_n = 1'b1;
    expect_at(0, 32'h4109_3000, "R1");
    expect_at(1, 32'h0, "R1");
    expect_at(5, 32'h0, "R1");
    expect_at(7, 32'h0, "R1");
    expect_at(8, 32'h0, "R1");

    wr(5, 32'hFFFF_FFE2);
    expect_at(5, 32'h2, "R2");
    wr(5, 0); wr(6, 1);
    wr(5, 1); wr(6, 2);
    wr(5, 2); wr(6, 0);
    wr(5, 3); wr(6, 8);
    wr(5, 7); wr(6, 5);
    expect_at(6, 32'h0, "R4");
    wr(5, 3);
    expect_at(6, 32'h8, "R4");

    wr(1, 32'hFFFF_FFFF); wr(2, 32'h0000_0002); wr(1, 32'h0);
    expect_at(1, 32'h8000_000D, "R3");
    wr(0, 32'h1);

    for (int c = 0; c < 6; c++) begin
      @(negedge clk); reg_wr = 1'b0; reg_addr = 4'd7; ev_in = 8'(8'h81 << (c % 2));
    end
    @(negedge clk); ev_in = 8'hFF;
    @(negedge clk); ev_in = 8'h00;
    wr(5, 0); rd(7, 2);
    wr(5, 1); rd(7, 2);

    wr(5, 2); wr(4, 32'hF); wr(4, 32'h4); wr(4, 32'h0);
    expect_at(7, 32'h2, "R10");

    wr(5, 0); wr(7, 32'hFFFF_FFFE);
    expect_at(7, 32'hFFFF_FFFE, "R11");
    @(negedge clk); ev_in = 8'h01; reg_wr = 0;
    @(negedge clk);
    @(negedge clk); ev_in = 8'h00;
    expect_at(3, 32'h0000_0001, "R6");
    rd(3, 3);
    wr(3, 32'h1);
    expect_at(3, 32'h0, "R6");

    wr(8, 32'hFFFF_FFF0); rd(8, 20); rd(3, 2);
    wr(3, 32'h8000_0000); rd(3, 2);

    wr(0, 32'h5);
    expect_at(8, 32'h1, "R9");
    wr(0, 32'h9); rd(8, 140);
    wr(0, 32'h1); rd(0, 2);

    @(negedge clk); dbg_en = 1'b0; ev_in = 8'hFF; reg_wr = 0; reg_addr = 4'd7;
    @(posedge clk); #5; check("R8", reg_rdata, 32'h0);
    rd(8, 5);
    @(negedge clk); dbg_en = 1'b1; ev_in = 8'h00;
    expect_at(7, 32'h0, "R8");
    wr(0, 32'h3);
    expect_at(7, 32'h0, "R9");
    expect_at(0, 32'h4109_3001, "R9");

    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      ev_in  = 8'($urandom);
      dbg_en = ($urandom % 16) != 0;
      reg_wr = ($urandom % 3) == 0;
      reg_addr = 4'($urandom % 9);
      reg_wdata = $urandom;
      if (reg_wr && reg_addr == 4'd5) reg_wdata = $urandom % 6;
      if (reg_wr && reg_addr == 4'd6) reg_wdata = $urandom % 10;
      if (reg_wr && reg_addr == 4'd0) reg_wdata = {28'd0, 2'($urandom), 2'b01};
    end
    rd(0, 2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule